// File: doc/BRIEF.md
# Real-Time Clock Interrupt Status Register

This block holds the interrupt status byte of a PC-style real-time clock. It receives one-cycle event pulses from the periodic, alarm and update-ended generators and the control byte that holds the enables. For each source it keeps a sticky flag. It exposes the status byte on a read port and drives one active-high interrupt request.

A flag latches whenever its event fires, whether or not its enable is set. The summary bit and the interrupt request respond only to flags whose enable is set. A read strobe from the register bus empties the register on the following clock. An event that arrives in the same cycle as that read is kept.

Top module: `rtc_irq_status`

## Requirements
- R1: A pulse on `evt_i[2]` (periodic), `evt_i[1]` (alarm) or `evt_i[0]` (update-ended) sets status bit 6, 5 or 4 respectively after the next clock edge, whatever the enable bits hold.
- R2: A set flag keeps its value until a read strobe or a reset.
- R3: Status bit 7 (summary) becomes 1 after the edge at which a latched or arriving flag has its enable set. The enables are control bits 6, 5 and 4, in the same order as the flags. Flags whose enable is clear never set bit 7.
- R4: Setting an enable while its flag is already latched sets bit 7 and raises `irq_o` after the next edge.
- R5: `irq_o` is registered. After an edge it is 1 only if bit 7 is 1 and at least one latched flag has its enable set. If every enable is cleared, `irq_o` drops after the next edge while bit 7 stays at 1 until a read.
- R6: A read strobe with no event present clears bits 7 to 4 and `irq_o` after the next edge.
- R7: An event that arrives in the same cycle as a read strobe remains latched after that edge. It also sets bit 7 and `irq_o` if its enable is set.
- R8: Status bits 3 to 0 always read as zero. Control bits other than 6, 5 and 4 have no effect.
- R9: While `rst_i` is high at an edge, that edge clears the whole status byte and `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| evt_i | input | 3 | Event pulses: [2] periodic, [1] alarm, [0] update-ended |
| ctrl_i | input | 8 | Control byte. Enables are in bits 6, 5 and 4 |
| rd_i | input | 1 | Read strobe for the status byte. Clears the byte on the next edge |
| status_o | output | 8 | Status byte: bit 7 summary, bits 6 to 4 flags, bits 3 to 0 zero |
| irq_o | output | 1 | Interrupt request, active high, registered |

## Verification
The bench goes after an event that coincides with a read. A design that cleared unconditionally would lose that flag and the interrupt.

It also enables a flag that latched while its enable was off. A design that evaluated the summary only on event arrival would leave bit 7 and `irq_o` low.

It clears every enable while the summary bit is set. A design that tied `irq_o` straight to the summary bit would keep requesting, and one that recomputed the summary would lose the sticky bit 7.

Finally, it sets the control bits that carry no enable. A misplaced mask would then leak interrupts or fill the lower nibble.

// File: rtl/rtcirq_pkg.sv
package rtcirq_pkg;
   // Source order inside the flag vector: highest index is the periodic source
   localparam int unsigned SRC_UPDATE   = 0;
   localparam int unsigned SRC_ALARM    = 1;
   localparam int unsigned SRC_PERIODIC = 2;

   // True when any enabled bit of a vector is set
   function automatic logic any_armed(input logic [31:0] bits, input logic [31:0] mask);
      return |(bits & mask);
   endfunction
endpackage

// File: rtl/rtcirq_flag_cell.sv
module rtcirq_flag_cell (
   input  logic clk_i,
   input  logic rst_i,
   input  logic evt_i,
   input  logic clr_i,
   output logic flag_o
);
   logic flag_q;

   always_ff @(posedge clk_i) begin
      if (rst_i)      flag_q <= 1'b0;
      else if (clr_i) flag_q <= evt_i;
      else            flag_q <= flag_q | evt_i;
   end

   assign flag_o = flag_q;

   // R1 / R7: an event always leaves the flag set, read or not
   a_r1_latch_evt: assert property (@(posedge clk_i) disable iff (rst_i)
      evt_i |=> flag_o);
   // R2: a set flag survives a cycle without a read
   a_r2_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
      (flag_o && !clr_i) |=> flag_o);
   // R6: a read without a coincident event empties the flag
   a_r6_clear: assert property (@(posedge clk_i) disable iff (rst_i)
      (clr_i && !evt_i) |=> !flag_o);
endmodule

// File: rtl/rtcirq_summary.sv
module rtcirq_summary #(
   parameter int unsigned NUM_SRC = 3
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               clr_i,
   input  logic [NUM_SRC-1:0] evt_i,
   input  logic [NUM_SRC-1:0] flags_i,
   input  logic [NUM_SRC-1:0] en_i,
   output logic               irqf_o,
   output logic               irq_o
);
   import rtcirq_pkg::*;

   logic [NUM_SRC-1:0] flags_nxt;
   logic               hit;
   logic               irqf_nxt;
   logic               irqf_q;
   logic               irq_q;

   always_comb begin
      flags_nxt = clr_i ? evt_i : (flags_i | evt_i);
      hit       = any_armed(32'(flags_nxt), 32'(en_i));
      irqf_nxt  = clr_i ? hit : (irqf_q | hit);
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         irqf_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         irqf_q <= irqf_nxt;
         irq_q  <= irqf_nxt & hit;
      end
   end

   assign irqf_o = irqf_q;
   assign irq_o  = irq_q;

   // R5: request never stands without the summary bit
   a_r5_irq_needs_irqf: assert property (@(posedge clk_i) disable iff (rst_i)
      irq_o |-> irqf_o);
   // R3: the summary bit rises only from an enabled flag or event
   a_r3_rise_cause: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(irqf_o) |-> $past(|((evt_i | flags_i) & en_i)));
   // R5: with all enables off the request is low on the next cycle
   a_r5_drop_when_masked: assert property (@(posedge clk_i) disable iff (rst_i)
      (en_i == '0) |=> !irq_o);
endmodule

// File: rtl/rtc_irq_status.sv
module rtc_irq_status #(
   parameter int unsigned NUM_SRC  = 3,
   parameter int unsigned BYTE_W   = 8,
   parameter int unsigned FLAG_LSB = 4
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [2:0]        evt_i,
   input  logic [7:0]        ctrl_i,
   input  logic              rd_i,
   output logic [7:0]        status_o,
   output logic              irq_o
);
   localparam int unsigned SUM_POS  = FLAG_LSB + NUM_SRC;
   localparam int unsigned FLAG_MSB = SUM_POS - 1;

   generate
      if (SUM_POS >= BYTE_W) begin : g_bad_layout
         $error("rtc_irq_status: flags and summary bit do not fit in the byte");
      end
      if (NUM_SRC != 3) begin : g_bad_src
         $error("rtc_irq_status: port list carries exactly three sources");
      end
      if (BYTE_W != 8) begin : g_bad_width
         $error("rtc_irq_status: status and control ports are byte wide");
      end
   endgenerate

   logic [NUM_SRC-1:0] flags;
   logic [NUM_SRC-1:0] en;
   logic               irqf;

   assign en = ctrl_i[FLAG_MSB:FLAG_LSB];

   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
         rtcirq_flag_cell u_cell (
            .clk_i (clk_i),
            .rst_i (rst_i),
            .evt_i (evt_i[i]),
            .clr_i (rd_i),
            .flag_o(flags[i])
         );
      end
   endgenerate

   rtcirq_summary #(.NUM_SRC(NUM_SRC)) u_sum (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .clr_i  (rd_i),
      .evt_i  (evt_i),
      .flags_i(flags),
      .en_i   (en),
      .irqf_o (irqf),
      .irq_o  (irq_o)
   );

   always_comb begin
      status_o                   = '0;
      status_o[SUM_POS]          = irqf;
      status_o[FLAG_MSB:FLAG_LSB] = flags;
   end

   // R9: a reset edge leaves everything clear
   a_r9_reset_clear: assert property (@(posedge clk_i)
      rst_i |=> (status_o == '0 && !irq_o));
   // R4 / R5: a request implies a latched flag that was enabled
   a_r4_irq_has_source: assert property (@(posedge clk_i) disable iff (rst_i)
      irq_o |-> |(status_o[FLAG_MSB:FLAG_LSB] & $past(en)));
   // R3: bit 7 is set by the first edge that sees a latched flag enabled
   a_r3_armed_sets_sum: assert property (@(posedge clk_i) disable iff (rst_i)
      (|(status_o[FLAG_MSB:FLAG_LSB] & en) && !rd_i) |=> status_o[SUM_POS]);
endmodule

// File: tb/sim_rtc_irq_status.sv
`timescale 1ns/1ps
module sim_rtc_irq_status;
   logic       clk = 1'b0;
   logic       rst;
   logic [2:0] evt;
   logic [7:0] ctrl;
   logic       rd;
   logic [7:0] status;
   logic       irq;

   typedef struct {
      logic [7:0] st;
      logic       irq;
      string      tag;
   } exp_t;

   exp_t q[$];
   int   n_run  = 0;
   int   n_fail = 0;
   bit   done   = 1'b0;

   always #2.5 clk = ~clk;

   rtc_irq_status u0 (
      .clk_i(clk), .rst_i(rst), .evt_i(evt), .ctrl_i(ctrl),
      .rd_i(rd), .status_o(status), .irq_o(irq)
   );

   // Driver: apply one cycle of stimulus, queue what must be seen after the edge
   task automatic cyc(input logic r, input logic [2:0] e, input logic [7:0] c,
                      input logic rdv, input logic [7:0] est, input logic eirq,
                      input string tag);
      exp_t x;
      @(negedge clk);
      rst = r; evt = e; ctrl = c; rd = rdv;
      x.st = est; x.irq = eirq; x.tag = tag;
      q.push_back(x);
   endtask

   // Monitor: compare just after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            exp_t x;
            x = q.pop_front();
            n_run++;
            if (status !== x.st || irq !== x.irq) begin
               n_fail++;
               $display("FAIL %s: status=%02h irq=%0b expected status=%02h irq=%0b",
                        x.tag, status, irq, x.st, x.irq);
            end
         end
      end
   end

   initial begin
      rst = 1'b1; evt = '0; ctrl = '0; rd = 1'b0;
      cyc(1, 3'b000, 8'h00, 0, 8'h00, 0, "R9 reset state");
      cyc(1, 3'b111, 8'h70, 0, 8'h00, 0, "R9 reset wins over events");
      cyc(0, 3'b100, 8'h00, 0, 8'h40, 0, "R1 periodic latches while disabled");
      cyc(0, 3'b000, 8'h00, 0, 8'h40, 0, "R2 flag sticky");
      cyc(0, 3'b010, 8'h00, 0, 8'h60, 0, "R1 alarm latches while disabled");
      cyc(0, 3'b000, 8'h00, 1, 8'h00, 0, "R6 read clears");
      cyc(0, 3'b010, 8'h20, 0, 8'hA0, 1, "R3 enabled alarm sets summary");
      cyc(0, 3'b000, 8'h20, 0, 8'hA0, 1, "R2 summary and request hold");
      cyc(0, 3'b000, 8'h00, 0, 8'hA0, 0, "R5 masking drops request, summary stays");
      cyc(0, 3'b000, 8'h00, 1, 8'h00, 0, "R6 read clears summary");
      cyc(0, 3'b100, 8'h10, 0, 8'h40, 0, "R3 disabled flag leaves summary low");
      cyc(0, 3'b000, 8'h50, 0, 8'hC0, 1, "R4 late enable of latched flag");
      cyc(0, 3'b001, 8'h50, 1, 8'h90, 1, "R7 event during read kept");
      cyc(0, 3'b000, 8'h50, 1, 8'h00, 0, "R6 second read clears");
      cyc(0, 3'b111, 8'h8F, 0, 8'h70, 0, "R8 non-enable control bits ignored");
      cyc(0, 3'b000, 8'h8F, 1, 8'h00, 0, "R6 read after R8 case");
      cyc(0, 3'b001, 8'h70, 0, 8'h90, 1, "R3 update enabled");
      cyc(1, 3'b000, 8'h70, 0, 8'h00, 0, "R9 reset mid-run");
      cyc(0, 3'b111, 8'h70, 0, 8'hF0, 1, "R1 all flags with all enables");
      cyc(0, 3'b110, 8'h00, 1, 8'h60, 0, "R7 disabled events during read kept");
      cyc(0, 3'b000, 8'h00, 1, 8'h00, 0, "R8 lower nibble zero after clear");
      cyc(0, 3'b000, 8'h00, 0, 8'h00, 0, "R6 idle stays clear");
      repeat (3) @(negedge clk);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            #20000;
            if (!done) begin
               n_fail++;
               n_run++;
               $display("FAIL watchdog: run hung, expected completion");
            end
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule